// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is a down-counter whose width is a parameter, fed through a power-of-two prescaler. It comes out of reset as a system watchdog. In that mode software must keep rewriting the load register with a new value. If the counter runs out, the block raises a one-cycle reset request and puts every register back to its power-up value.

After a two-write unlock sequence on the mode register, the same counter serves as a general-purpose interval timer. It can be started and stopped, it can run once or reload itself, its prescaler is selectable, and it pulses an interrupt each time a decrement reaches zero.

Software reaches the block through a small word-addressed register port. Address 0 is the mode register, where bit 15 reads 1 in watchdog mode. Address 1 is the control register: bit 7 is start, bit 3 is auto-reload, and bits 2:0 are the prescale setting. Address 2 is the load register. Address 3 returns the live count. Writes take effect at the clock edge where `wr_en` is high, and reads are combinational.

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset the block is in watchdog mode. The mode register reads 0x8000, the load register and the counter hold all ones, the control register reads 0, and both `irq` and `wdt_reset` are low.
- R2: In watchdog mode the counter decrements once every 256 clock cycles, whatever the prescale field holds.
- R3: In watchdog mode, a prescaler tick that finds the counter at zero drives `wdt_reset` high for exactly one cycle. At that edge the mode, load, counter and control registers return to their R1 values, and this takes priority over any write in the same cycle.
- R4: In watchdog mode, an accepted load write sets both the load register and the counter to the written value and restarts the prescaler.
- R5: In watchdog mode, a load write whose value equals the current load register is ignored. It changes neither the load register nor the counter.
- R6: After an accepted load write, any load write in the following 3 clock cycles is ignored.
- R7: In watchdog mode, writes to the control register are ignored. The control register keeps reading 0 and counting continues.
- R8: Watchdog mode is left only by writing 0x00F5 and then 0x00A0 to the mode register in two consecutive register writes. Any other register write in between, and any other value, cancels the sequence. Writing 0 to bit 15 alone does not leave watchdog mode. On leaving, the counter stops and holds its value.
- R9: In timer mode, a mode write with bit 15 set returns the block to watchdog mode. The load register and the counter become all ones and the control register becomes 0.
- R10: In timer mode, writing start=1 while stopped loads the counter from the load register and counts down once every 2^(N+1) cycles, where N is the prescale field. Writing start=0 freezes the counter.
- R11: With auto-reload 0, a tick at zero stops the timer and clears the start bit. With auto-reload 1, a tick at zero reloads the counter from the load register.
- R12: In timer mode, `irq` is high for one cycle after each decrement that takes the counter to zero, and it never rises in watchdog mode.
- R13: While the timer runs, writes to the load register and to the prescale and auto-reload fields are ignored.
- R14: Address 3 always reads the live counter value, whether the counter is running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mode, 1 control, 2 load, 3 count |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Timer-mode zero-reach pulse |
| wdt_reset | output | 1 | Watchdog expiry reset request, one-cycle pulse |

## Verification
Every register effect of a write is visible on `rdata` in the cycle after the edge that captured the write. `irq` and `wdt_reset` are registered, so each pulse appears in the cycle after the tick edge that caused it. The bench updates its behavioural model at each rising edge and compares all outputs 15 ns later, when the design has settled and before the next input change. Directed reads are sampled at the same point, so the counter ticks and the 3-cycle refresh guard are counted exactly in whole edges.

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer #(
  parameter int CNT_W = 16,
  parameter int PS_W = 3,
  parameter int GUARD = 3,
  parameter logic [15:0] KEY1 = 16'h00F5,
  parameter logic [15:0] KEY2 = 16'h00A0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        wdt_reset
);
  localparam int PSC_W = 1 << PS_W;
  localparam int GW = $clog2(GUARD + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PS_W-1:0] PS_MAX = '1;

  logic             wd_q, start_q, ar_q, arm_q, irq_q, wrst_q;
  logic [PS_W-1:0]  psv_q;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic [PSC_W-1:0] ps_q;
  logic [GW-1:0]    guard_q;

  wire [PS_W-1:0]  ps_sel  = wd_q ? PS_MAX : psv_q;
  wire [PSC_W-1:0] ps_mask = PSC_W'((32'd2 << ps_sel) - 32'd1);
  wire running   = wd_q | start_q;
  wire tick      = running & (&(ps_q | ~ps_mask));
  wire cnt_zero  = (cnt_q == '0);
  wire underflow = wd_q & tick & cnt_zero;

  wire wr_mode = wr_en & (addr == 2'd0);
  wire wr_ctrl = wr_en & (addr == 2'd1);
  wire wr_load = wr_en & (addr == 2'd2);

  wire key_hit  = wd_q & wr_mode & arm_q & (wdata == KEY2);
  wire wd_enter = ~wd_q & wr_mode & wdata[15];
  wire load_ok  = wr_load & (guard_q == '0) &
                  (wd_q ? (wdata[CNT_W-1:0] != load_q) : ~start_q);
  wire refresh  = load_ok & wd_q;
  wire ctrl_ok  = wr_ctrl & ~wd_q;
  wire do_start = ctrl_ok & ~start_q & wdata[7];
  wire do_stop  = (ctrl_ok & start_q & ~wdata[7]) | key_hit;
  wire cnt_load = refresh | do_start | wd_enter;
  wire os_end   = ~wd_q & tick & cnt_zero & ~ar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q <= 1'b1; start_q <= 1'b0; ar_q <= 1'b0; psv_q <= '0;
      load_q <= CNT_MAX; cnt_q <= CNT_MAX; ps_q <= '0;
      arm_q <= 1'b0; guard_q <= '0; irq_q <= 1'b0; wrst_q <= 1'b0;
    end else if (underflow) begin
      wd_q <= 1'b1; start_q <= 1'b0; ar_q <= 1'b0; psv_q <= '0;
      load_q <= CNT_MAX; cnt_q <= CNT_MAX; ps_q <= '0;
      arm_q <= 1'b0; guard_q <= '0; irq_q <= 1'b0; wrst_q <= 1'b1;
    end else begin
      wrst_q <= 1'b0;
      irq_q  <= ~wd_q & tick & ~cnt_load & ~do_stop & (cnt_q == CNT_W'(1));

      if (key_hit)       wd_q <= 1'b0;
      else if (wd_enter) wd_q <= 1'b1;

      if (wr_en) arm_q <= wd_q & wr_mode & (wdata == KEY1);

      if (wd_enter) begin
        start_q <= 1'b0; ar_q <= 1'b0; psv_q <= '0;
      end else begin
        if (ctrl_ok & ~start_q) begin
          ar_q  <= wdata[3];
          psv_q <= wdata[PS_W-1:0];
        end
        if (do_start)              start_q <= 1'b1;
        else if (do_stop | os_end) start_q <= 1'b0;
      end

      if (wd_enter)     load_q <= CNT_MAX;
      else if (load_ok) load_q <= wdata[CNT_W-1:0];

      if (load_ok)              guard_q <= GW'(GUARD);
      else if (guard_q != '0)   guard_q <= guard_q - 1'b1;

      if (wd_enter)      cnt_q <= CNT_MAX;
      else if (refresh)  cnt_q <= wdata[CNT_W-1:0];
      else if (do_start) cnt_q <= load_q;
      else if (!do_stop && tick) begin
        if (!cnt_zero)   cnt_q <= cnt_q - 1'b1;
        else if (ar_q)   cnt_q <= load_q;
      end

      if (cnt_load | do_stop) ps_q <= '0;
      else if (running)       ps_q <= ps_q + 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {wd_q, 15'd0};
      2'd1:    rdata = {8'd0, start_q, 3'd0, ar_q, 3'(psv_q)};
      2'd2:    rdata = 16'(load_q);
      default: rdata = 16'(cnt_q);
    endcase
  end

  assign irq = irq_q;
  assign wdt_reset = wrst_q;
endmodule

module wdt_interval_timer_chk #(
  parameter int CNT_W = 16,
  parameter logic [15:0] KEY2 = 16'h00A0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [15:0]      wdata,
  input logic             irq,
  input logic             wdt_reset,
  input logic             wd_q,
  input logic             start_q,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] cnt_q
);
  p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);
  p_rst_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> (wd_q && load_q == '1 && cnt_q == '1 && !start_q));
  p_same_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q && wr_en && addr == 2'd2 && wdata[CNT_W-1:0] == load_q)
    |=> ($stable(load_q) || wdt_reset));
  p_ctrl_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_q |-> !start_q);
  p_exit_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_q) |-> $past(wr_en && addr == 2'd0 && wdata == KEY2));
  p_enter_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_q) |-> (load_q == '1 && cnt_q == '1));
  p_stop_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_q && !start_q) |=> ($stable(cnt_q) || wd_q || start_q));
  p_irq_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == '0 && !wd_q));
endmodule

bind wdt_interval_timer wdt_interval_timer_chk #(.CNT_W(CNT_W), .KEY2(KEY2)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .wdt_reset(wdt_reset), .wd_q(wd_q), .start_q(start_q),
  .load_q(load_q), .cnt_q(cnt_q)
);

// File: tb/test_wdt_interval_timer.sv
module test_wdt_interval_timer;
  localparam int W = 8;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = 16'd0, rdata;
  logic irq, wdt_reset;

  always #10 clk = ~clk;

  wdt_interval_timer #(.CNT_W(W)) i_wdt_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .wdt_reset(wdt_reset));

  int compared = 0, mismatched = 0;
  int irq_cnt = 0, rst_cnt = 0;

  int m_wd, m_start, m_ar, m_ps, m_load, m_cnt, m_arm, m_guard, m_pre, m_irq, m_wrst;

  task automatic m_init();
    m_wd = 1; m_start = 0; m_ar = 0; m_ps = 0; m_load = MAXC; m_cnt = MAXC;
    m_arm = 0; m_guard = 0; m_pre = 0; m_irq = 0;
  endtask

  task automatic m_step();
    int div, n_cnt, n_load;
    bit run, tk, wm, wc, wl, key, enter, lok, st, sp, ld;
    logic [15:0] v;
    v = wdata;
    div = 2 ** ((m_wd != 0 ? 7 : m_ps) + 1);
    run = (m_wd != 0) || (m_start != 0);
    tk = run && (m_pre % div == div - 1);
    if (m_wd != 0 && tk && m_cnt == 0) begin
      m_init(); m_wrst = 1; return;
    end
    m_wrst = 0;
    wm = wr_en && addr == 0; wc = wr_en && addr == 1; wl = wr_en && addr == 2;
    key = m_wd != 0 && wm && m_arm != 0 && v == 16'h00A0;
    enter = m_wd == 0 && wm && v[15];
    lok = wl && m_guard == 0 &&
          ((m_wd != 0) ? (int'(v) & MAXC) != m_load : m_start == 0);
    st = wc && m_wd == 0 && m_start == 0 && v[7];
    sp = (wc && m_wd == 0 && m_start != 0 && !v[7]) || key;
    ld = (lok && m_wd != 0) || st || enter;
    m_irq = (m_wd == 0 && tk && !ld && !sp && m_cnt == 1) ? 1 : 0;
    n_cnt = m_cnt;
    if (enter) n_cnt = MAXC;
    else if (lok && m_wd != 0) n_cnt = int'(v) & MAXC;
    else if (st) n_cnt = m_load;
    else if (!sp && tk) begin
      if (m_cnt > 0) n_cnt = m_cnt - 1;
      else if (m_ar != 0) n_cnt = m_load;
    end
    n_load = enter ? MAXC : (lok ? (int'(v) & MAXC) : m_load);
    if (enter) begin
      m_start = 0; m_ar = 0; m_ps = 0;
    end else begin
      if (st) m_start = 1;
      else if (sp || (m_wd == 0 && tk && m_cnt == 0 && m_ar == 0)) m_start = 0;
      if (wc && m_wd == 0 && run == 0) begin
        m_ar = v[3]; m_ps = int'(v[2:0]);
      end
    end
    if (wr_en) m_arm = (m_wd != 0 && wm && v == 16'h00F5) ? 1 : 0;
    if (key) m_wd = 0; else if (enter) m_wd = 1;
    m_guard = lok ? 3 : (m_guard > 0 ? m_guard - 1 : 0);
    if (ld || sp) m_pre = 0; else if (run) m_pre = (m_pre + 1) % 256;
    m_cnt = n_cnt; m_load = n_load;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_init(); m_wrst = 0; end
    else m_step();
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_wd << 15;
      1: return (m_start << 7) | (m_ar << 3) | m_ps;
      2: return m_load;
      default: return m_cnt;
    endcase
  endfunction

  always @(posedge clk) begin
    #15;
    if (irq) irq_cnt++;
    if (wdt_reset) rst_cnt++;
    case (addr)
      2'd0: chk("R8 mode read", int'(rdata), exp_rd(0));
      2'd1: chk("R7 control read", int'(rdata), exp_rd(1));
      2'd2: chk("R4 load read", int'(rdata), exp_rd(2));
      default: chk("R14 count read", int'(rdata), exp_rd(3));
    endcase
    chk("R12 irq", int'(irq), m_irq);
    chk("R3 wdt_reset", int'(wdt_reset), m_wrst);
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #5; wr_en = 1'b1; addr = 2'(a); wdata = 16'(d);
  endtask
  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #5; wr_en = 1'b0; end
  endtask
  task automatic rd(input int a, output int v);
    @(posedge clk); #5; wr_en = 1'b0; addr = 2'(a); #10; v = int'(rdata);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    int v, v2;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    #10;
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 wdt_reset after reset", int'(wdt_reset), 0);
    rd(0, v); chk("R1 mode", v, 16'h8000);
    rd(1, v); chk("R1 control", v, 0);
    rd(2, v); chk("R1 load", v, MAXC);
    rd(3, v); chk("R1 count", v, MAXC);
    idle(300);
    rd(3, v); chk("R2 one tick in 300 cycles", v, MAXC - 1);
    wr(1, 16'h0080);
    rd(1, v); chk("R7 control locked", v, 0);
    wr(2, 16'h0040);
    rd(3, v); chk("R4 refresh count", v, 16'h40);
    rd(2, v); chk("R4 refresh load", v, 16'h40);
    idle(300);
    rd(3, v); chk("R2 tick after refresh", v, 16'h3F);
    wr(2, 16'h0040);
    rd(2, v); chk("R5 same value load", v, 16'h40);
    rd(3, v); chk("R5 same value count", v, 16'h3F);
    wr(2, 16'h0030); wr(2, 16'h0020);
    rd(2, v); chk("R6 back to back ignored", v, 16'h30);
    idle(5);
    wr(2, 16'h0031); idle(2); wr(2, 16'h0011);
    rd(2, v); chk("R6 third cycle ignored", v, 16'h31);
    idle(1); wr(2, 16'h0021);
    rd(2, v); chk("R6 after guard accepted", v, 16'h21);
    wr(0, 16'h0000);
    rd(0, v); chk("R8 clear bit alone", v, 16'h8000);
    wr(0, 16'h00F5); wr(2, 16'h0055); wr(0, 16'h00A0);
    rd(0, v); chk("R8 broken sequence", v, 16'h8000);
    idle(5);
    wr(0, 16'h00F5); wr(0, 16'h00A0);
    rd(0, v); chk("R8 unlocked", v, 0);
    rd(3, v); idle(300); rd(3, v2);
    chk("R10 frozen after unlock", v2, v);
    wr(2, 5); wr(1, 16'h0080);
    irq_cnt = 0;
    idle(40);
    rd(3, v); chk("R11 one-shot ends at zero", v, 0);
    rd(1, v); chk("R11 start cleared", v, 0);
    chk("R12 one irq pulse", irq_cnt, 1);
    wr(2, 3); wr(1, 16'h0089);
    irq_cnt = 0;
    idle(100);
    chk("R11 auto-reload repeats", int'(irq_cnt >= 5 && irq_cnt <= 7), 1);
    wr(1, 16'h0087); idle(4); wr(2, 9);
    rd(2, v); chk("R13 load ignored while running", v, 3);
    rd(1, v); chk("R13 fields ignored while running", v, 16'h89);
    wr(1, 0);
    rd(3, v); idle(50); rd(3, v2);
    chk("R10 stop freezes", v2, v);
    rd(1, v); chk("R10 stopped control", v, 16'h09);
    wr(0, 16'h8000);
    rd(0, v); chk("R9 back to watchdog", v, 16'h8000);
    rd(2, v); chk("R9 load max", v, MAXC);
    rd(3, v); chk("R9 count max", v, MAXC);
    rd(1, v); chk("R9 control cleared", v, 0);
    rst_cnt = 0;
    for (int i = 0; i < 700 && rst_cnt == 0; i++) idle(100);
    chk("R3 one reset pulse", rst_cnt, 1);
    rd(0, v); chk("R3 mode restored", v, 16'h8000);
    rd(2, v); chk("R3 load restored", v, MAXC);
    idle(3);
    finish_run();
  end
endmodule